// File: doc/BRIEF.md
# Real-Time Clock with Delayed Register Writes

This block is a real-time clock peripheral behind a simple APB-style register port. It runs two counters: a fractional-second counter that wraps at a parameterised modulus, and a whole-second counter that steps each time the fractional counter wraps. Each counter has a compare register. When a counter equals its compare value and the matching interrupt enable is set, a sticky interrupt flag is raised. The interrupt output is high while either flag is set. Software clears a flag by writing a one to its bit in a write-only clear register.

Writes do not take effect at once. Each one is held in flight for a fixed number of cycles. This stands in for the crossing into a slow counting domain, which is modelled here as a fixed-latency path. While a write is in flight, the status register shows a busy flag for its target and a summary busy flag. A second write to a target that is still busy is refused and sets a sticky error flag. The in-flight write then completes unchanged. Any write to the status register clears the error flag.

Top module: `rtc_periph`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low.
- R2: A write to word offset 0x00 (fractional count), 0x04 (second count), 0x08 (fractional compare), 0x0C (second compare) or 0x10 (control) is accepted in the cycle with `psel`, `penable` and `pwrite` high. Readback keeps the old value for `WR_LAT` cycles and shows the new value afterwards.
- R3: For those `WR_LAT` cycles, status bit 3 (any write busy) is high, together with the per-target busy bit. The per-target bits are: bit 4 fractional count, bit 5 second count, bit 6 fractional compare, bit 7 second compare, bit 8 control, bit 9 fractional-flag clear, bit 10 second-flag clear.
- R4: A write to a target whose busy bit is high sets status bit 2 (write error), and the bit stays set. Writes to targets that are not busy do not set it.
- R5: A refused write is discarded, and the earlier in-flight write to that target completes with its own data.
- R6: Any write to offset 0x14 (status) clears status bit 2 from the next cycle, whatever the data.
- R7: When control bit 0 is 1, the fractional counter advances by one per cycle and goes from `SUB_WRAP-1` to 0.
- R8: When control bit 1 is 1, the second counter advances by one in each cycle where the fractional counter wraps.
- R9: A counter whose enable bit (control bit 0 or bit 1) is 0 keeps its value.
- R10: Status bit 0 (fractional flag) sets when the fractional counter equals its compare value while control bit 2 is 1. Status bit 1 (second flag) sets in the same way, using control bit 3. Both flags are sticky, and a flag never sets while its enable bit is 0.
- R11: At offset 0x18, a write with data bit 0 set clears status bit 0 and a write with data bit 1 set clears status bit 1, each after `WR_LAT` cycles. A zero bit has no effect and starts no busy flag. The register reads as zero.
- R12: `irq` equals the OR of status bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Byte address; word aligned |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data, combinational from `paddr` |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with `SUB_WRAP=8`, `WR_LAT=4` and `SEC_W=16`. With a modulus of 8, fractional wraps and second-counter carries happen every few cycles. This lets the bench reach every fractional compare value in a sweep, and lets it compute elapsed ticks as `sec*8+sub` for count windows of several lengths. A latency of 4 leaves a wide enough window for back-to-back bus writes to land while a target is still busy. That exercises the refusal path and checks that each of the seven busy bits sits at its own position.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // in-flight write slots (index = status bit position minus 4)
   localparam int NSLOT     = 7;
   localparam int SL_SUBCNT = 0;
   localparam int SL_SECCNT = 1;
   localparam int SL_SUBALM = 2;
   localparam int SL_SECALM = 3;
   localparam int SL_CTRL   = 4;
   localparam int SL_SUBCLR = 5;
   localparam int SL_SECCLR = 6;

   // register word indices (byte offset / 4)
   localparam logic [2:0] RW_SUBCNT = 3'd0;
   localparam logic [2:0] RW_SECCNT = 3'd1;
   localparam logic [2:0] RW_SUBALM = 3'd2;
   localparam logic [2:0] RW_SECALM = 3'd3;
   localparam logic [2:0] RW_CTRL   = 3'd4;
   localparam logic [2:0] RW_STAT   = 3'd5;
   localparam logic [2:0] RW_ICLR   = 3'd6;

   typedef struct packed {
      logic sec_ie;
      logic sub_ie;
      logic sec_en;
      logic sub_en;
   } ctrl_t;

endpackage

// File: rtl/rtc_wr_slot.sv
module rtc_wr_slot #(
   parameter int LAT = 4,
   parameter int DW  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          commit,
   output logic          collide,
   output logic [DW-1:0] cdata
);
   localparam int CW = $clog2(LAT + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         cdata  <= '0;
      end else if (req && (left_q == '0)) begin
         left_q <= CW'(LAT);
         cdata  <= wdata;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy    = (left_q != '0);
   assign commit  = (left_q == CW'(1));
   assign collide = req && busy;

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> (busy && cdata == $past(wdata)));
   assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && busy) |=> $stable(cdata));
   assert_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !req) |=> !busy);

endmodule

// File: rtl/rtc_wr_track.sv
module rtc_wr_track
   import rtc_pkg::*;
#(
   parameter int LAT = 4,
   parameter int DW  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NSLOT-1:0]           req,
   input  logic [DW-1:0]              wdata,
   input  logic                       err_clr,
   output logic [NSLOT-1:0]           busy,
   output logic [NSLOT-1:0]           commit,
   output logic [NSLOT-1:0][DW-1:0]   cdata,
   output logic                       err
);
   logic [NSLOT-1:0] collide;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      rtc_wr_slot #(.LAT(LAT), .DW(DW)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (req[s]),
         .wdata   (wdata),
         .busy    (busy[s]),
         .commit  (commit[s]),
         .collide (collide[s]),
         .cdata   (cdata[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            err <= 1'b0;
      else if (|collide)     err <= 1'b1;
      else if (err_clr)      err <= 1'b0;
   end

   assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req & busy)) |=> err);
   assert_err_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !err_clr) |=> err);

endmodule

// File: rtl/rtc_count_unit.sv
module rtc_count_unit
   import rtc_pkg::*;
#(
   parameter int SUB_WRAP = 32768,
   parameter int SEC_W    = 32,
   parameter int DW       = 32,
   localparam int SUB_W   = $clog2(SUB_WRAP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4:0]         commit,
   input  logic [4:0][DW-1:0] cdata,
   output logic [SUB_W-1:0]   sub_cnt,
   output logic [SEC_W-1:0]   sec_cnt,
   output logic [SUB_W-1:0]   sub_alm,
   output logic [SEC_W-1:0]   sec_alm,
   output ctrl_t              ctrl
);
   localparam bit POW2 = ((1 << SUB_W) == SUB_WRAP);

   logic at_top;
   logic sub_wrap;

   if (POW2) begin : g_wrap_pow2
      assign at_top = &sub_cnt;
   end else begin : g_wrap_cmp
      assign at_top = (sub_cnt >= SUB_W'(SUB_WRAP - 1));
   end

   assign sub_wrap = ctrl.sub_en && at_top;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_cnt <= '0;
         sec_cnt <= '0;
         sub_alm <= '0;
         sec_alm <= '0;
         ctrl    <= '0;
      end else begin
         if (commit[SL_SUBCNT])   sub_cnt <= cdata[SL_SUBCNT][SUB_W-1:0];
         else if (sub_wrap)       sub_cnt <= '0;
         else if (ctrl.sub_en)    sub_cnt <= sub_cnt + 1'b1;

         if (commit[SL_SECCNT])              sec_cnt <= cdata[SL_SECCNT][SEC_W-1:0];
         else if (sub_wrap && ctrl.sec_en)   sec_cnt <= sec_cnt + 1'b1;

         if (commit[SL_SUBALM]) sub_alm <= cdata[SL_SUBALM][SUB_W-1:0];
         if (commit[SL_SECALM]) sec_alm <= cdata[SL_SECALM][SEC_W-1:0];
         if (commit[SL_CTRL])   ctrl    <= ctrl_t'(cdata[SL_CTRL][3:0]);
      end
   end

   assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.sub_en && sub_cnt == SUB_W'(SUB_WRAP - 1) && !commit[SL_SUBCNT]) |=> (sub_cnt == '0));
   assert_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.sub_en && ctrl.sec_en && sub_cnt == SUB_W'(SUB_WRAP - 1) && !commit[SL_SECCNT])
      |=> (sec_cnt == SEC_W'($past(sec_cnt) + 1'b1)));
   assert_hold_sub_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.sub_en && !commit[SL_SUBCNT]) |=> $stable(sub_cnt));
   assert_hold_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.sec_en && !commit[SL_SECCNT]) |=> $stable(sec_cnt));

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] match,
   input  logic [1:0] ie,
   input  logic [1:0] clr,
   output logic [1:0] flag,
   output logic       irq
);
   for (genvar i = 0; i < 2; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                  flag[i] <= 1'b0;
         else if (clr[i])             flag[i] <= 1'b0;
         else if (match[i] && ie[i])  flag[i] <= 1'b1;
      end

      assert_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (match[i] && ie[i] && !clr[i]) |=> flag[i]);
      assert_noset_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag[i] && !ie[i]) |=> !flag[i]);
      assert_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] |=> !flag[i]);
   end

   assign irq = |flag;

endmodule

// File: rtl/rtc_periph.sv
module rtc_periph
   import rtc_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DW       = 32,
   parameter int WR_LAT   = 4,
   parameter int SUB_WRAP = 32768,
   parameter int SEC_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DW-1:0]     pwdata,
   output logic [DW-1:0]     prdata,
   output logic              irq
);
   localparam int SUB_W = $clog2(SUB_WRAP);

   if (WR_LAT < 1)                 begin : g_bad_lat   $error("WR_LAT must be at least 1");      end
   if (SUB_WRAP < 2)               begin : g_bad_wrap  $error("SUB_WRAP must be at least 2");    end
   if (DW < 11 || SEC_W > DW || SUB_W > DW) begin : g_bad_dw $error("data width too small"); end
   if (ADDR_W < 5)                 begin : g_bad_aw    $error("ADDR_W must be at least 5");      end

   // ---------------- address decode ----------------
   logic       hit;
   logic [2:0] idx;
   logic       wr;

   if (ADDR_W > 5) begin : g_upper
      assign hit = (paddr[ADDR_W-1:5] == '0) && (paddr[1:0] == 2'b00);
   end else begin : g_exact
      assign hit = (paddr[1:0] == 2'b00);
   end

   assign idx = paddr[4:2];
   assign wr  = psel && penable && pwrite && hit;

   logic [NSLOT-1:0] req;
   always_comb begin
      req            = '0;
      req[SL_SUBCNT] = wr && (idx == RW_SUBCNT);
      req[SL_SECCNT] = wr && (idx == RW_SECCNT);
      req[SL_SUBALM] = wr && (idx == RW_SUBALM);
      req[SL_SECALM] = wr && (idx == RW_SECALM);
      req[SL_CTRL]   = wr && (idx == RW_CTRL);
      req[SL_SUBCLR] = wr && (idx == RW_ICLR) && pwdata[0];
      req[SL_SECCLR] = wr && (idx == RW_ICLR) && pwdata[1];
   end

   logic stat_wr;
   assign stat_wr = wr && (idx == RW_STAT);

   // ---------------- write tracking ----------------
   logic [NSLOT-1:0]         busy;
   logic [NSLOT-1:0]         commit;
   logic [NSLOT-1:0][DW-1:0] cdata;
   logic                     err;

   rtc_wr_track #(.LAT(WR_LAT), .DW(DW)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .wdata   (pwdata),
      .err_clr (stat_wr),
      .busy    (busy),
      .commit  (commit),
      .cdata   (cdata),
      .err     (err)
   );

   // ---------------- counting ----------------
   logic [SUB_W-1:0] sub_cnt, sub_alm;
   logic [SEC_W-1:0] sec_cnt, sec_alm;
   ctrl_t            ctrl;

   rtc_count_unit #(.SUB_WRAP(SUB_WRAP), .SEC_W(SEC_W), .DW(DW)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit[4:0]),
      .cdata   (cdata[4:0]),
      .sub_cnt (sub_cnt),
      .sec_cnt (sec_cnt),
      .sub_alm (sub_alm),
      .sec_alm (sec_alm),
      .ctrl    (ctrl)
   );

   // ---------------- alarms ----------------
   logic [1:0] flag;

   rtc_irq_unit u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .match ({sec_cnt == sec_alm, sub_cnt == sub_alm}),
      .ie    ({ctrl.sec_ie, ctrl.sub_ie}),
      .clr   ({commit[SL_SECCLR], commit[SL_SUBCLR]}),
      .flag  (flag),
      .irq   (irq)
   );

   // ---------------- readback ----------------
   logic [DW-1:0] stat_word;
   always_comb begin
      stat_word        = '0;
      stat_word[1:0]   = flag;
      stat_word[2]     = err;
      stat_word[3]     = |busy;
      stat_word[10:4]  = busy;
   end

   always_comb begin
      prdata = '0;
      if (hit) begin
         case (idx)
            RW_SUBCNT: prdata = DW'(sub_cnt);
            RW_SECCNT: prdata = DW'(sec_cnt);
            RW_SUBALM: prdata = DW'(sub_alm);
            RW_SECALM: prdata = DW'(sec_alm);
            RW_CTRL:   prdata = DW'(ctrl);
            RW_STAT:   prdata = stat_word;
            default:   prdata = '0;
         endcase
      end
   end

   assert_stat_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> !err);
   assert_no_busy_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == RW_ICLR && pwdata[1:0] == 2'b00 && busy[SL_SUBCLR:SL_SUBCLR] == 1'b0)
      |=> !busy[SL_SUBCLR]);

endmodule

// File: tb/rtc_periph_bench.sv
module rtc_periph_bench;
   localparam int DW   = 32;
   localparam int LAT  = 4;
   localparam int WRAP = 8;
   localparam int SECW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [4:0]    paddr = '0;
   logic [DW-1:0] pwdata = '0;
   logic [DW-1:0] prdata;
   logic          irq;

   always #10 clk = ~clk;

   rtc_periph #(.ADDR_W(5), .DW(DW), .WR_LAT(LAT), .SUB_WRAP(WRAP), .SEC_W(SECW)) u_rtc_periph (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      paddr = a;
      #1;
      v = prdata;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_done(input logic [4:0] a, input logic [31:0] d);
      wr(a, d);
      idle(LAT);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   logic [31:0] v, a0, b0, s0, t0;
   logic [4:0]  offs [5];
   logic [31:0] vals [5];

   initial begin
      offs[0] = 5'h00; vals[0] = 3;
      offs[1] = 5'h04; vals[1] = 32'h1234;
      offs[2] = 5'h08; vals[2] = 5;
      offs[3] = 5'h0C; vals[3] = 32'h77;
      offs[4] = 5'h10; vals[4] = 32'hC;

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      for (int i = 0; i < 7; i++) begin
         rd(5'(i * 4), v);
         chk("R1 reset readback", v, 0);
      end
      chk("R1 reset irq", 32'(irq), 0);

      // R2/R3: latency and per-target busy position for each register
      for (int t = 0; t < 5; t++) begin
         wr(offs[t], vals[t]);
         rd(5'h14, v); chk("R3 busy bits at start", v, (32'h1 << 3) | (32'h1 << (4 + t)));
         rd(offs[t], v); chk("R2 old value while pending", v, 0);
         idle(LAT - 1);
         rd(5'h14, v); chk("R3 busy bits at end of window", v, (32'h1 << 3) | (32'h1 << (4 + t)));
         rd(offs[t], v); chk("R2 old value at end of window", v, 0);
         idle(1);
         rd(5'h14, v); chk("R3 busy cleared", v, 0);
         rd(offs[t], v); chk("R2 new value visible", v, vals[t]);
      end

      // R11: clear-register busy bits, zero write, readback
      wr(5'h18, 1); rd(5'h14, v); chk("R11 fractional clear busy bit9", v, 32'h208); idle(LAT);
      wr(5'h18, 2); rd(5'h14, v); chk("R11 second clear busy bit10", v, 32'h408); idle(LAT);
      wr(5'h18, 3); rd(5'h14, v); chk("R11 both clear busy", v, 32'h608); idle(LAT);
      wr(5'h18, 0); rd(5'h14, v); chk("R11 zero write starts no busy", v, 0);
      rd(5'h18, v); chk("R11 clear register reads zero", v, 0);

      // R4/R5: overlapping write to the same register
      wr(5'h08, 6);
      wr(5'h08, 1);
      rd(5'h14, v); chk("R4 error set with busy", v, 32'h4C);
      idle(LAT);
      rd(5'h08, v); chk("R5 first write kept", v, 6);
      rd(5'h14, v); chk("R4 error sticky", v, 32'h4);
      wr(5'h14, 32'hFFFF_FFFF);
      rd(5'h14, v); chk("R6 status write clears error", v, 0);
      wr(5'h08, 2);
      wr(5'h0C, 3);
      rd(5'h14, v); chk("R4 different targets no error", v & 32'h4, 0);
      idle(LAT);
      wr(5'h08, 2);
      wr(5'h08, 4);
      idle(LAT);
      wr(5'h14, 0);
      rd(5'h14, v); chk("R6 zero data also clears", v & 32'h4, 0);

      // R7/R9: fractional counting only
      wr_done(5'h10, 32'h1);
      for (int k = 1; k <= 12; k++) begin
         rd(5'h00, a0);
         idle(k);
         rd(5'h00, b0);
         chk("R7 fractional advance and wrap", b0, (a0 + 32'(k)) % WRAP);
         rd(5'h04, v);
         chk("R9 second held when disabled", v, 32'h1234);
      end

      // R8: carry into seconds
      wr_done(5'h10, 32'h3);
      for (int k = 1; k <= 25; k += 4) begin
         rd(5'h00, a0); rd(5'h04, s0);
         t0 = s0 * WRAP + a0;
         idle(k);
         rd(5'h00, b0); rd(5'h04, v);
         chk("R8 total ticks", v * WRAP + b0, t0 + 32'(k));
      end

      // R9: both held
      wr_done(5'h10, 32'h0);
      rd(5'h00, a0); rd(5'h04, s0);
      idle(11);
      rd(5'h00, b0); chk("R9 fractional hold", b0, a0);
      rd(5'h04, v);  chk("R9 second hold", v, s0);
      wr_done(5'h10, 32'h2);
      idle(2 * WRAP);
      rd(5'h04, v);  chk("R9 second idle without wraps", v, s0);
      wr_done(5'h10, 32'h0);

      // R10/R11/R12: fractional flag with counting stopped
      wr_done(5'h00, 4);
      wr_done(5'h08, 4);
      wr_done(5'h18, 3);
      rd(5'h14, v); chk("R10 no flag without enable", v & 32'h3, 0);
      wr_done(5'h10, 32'h4);
      idle(1);
      rd(5'h14, v); chk("R10 fractional flag set", v & 32'h3, 1);
      chk("R12 irq high", 32'(irq), 1);
      wr_done(5'h18, 2);
      rd(5'h14, v); chk("R11 other clear bit no effect", v & 32'h3, 1);
      wr_done(5'h08, 5);
      wr_done(5'h18, 1);
      rd(5'h14, v); chk("R11 fractional flag cleared", v & 32'h3, 0);
      chk("R12 irq low", 32'(irq), 0);

      // second flag
      wr_done(5'h04, 9);
      wr_done(5'h0C, 9);
      wr_done(5'h10, 32'h8);
      idle(1);
      rd(5'h14, v); chk("R10 second flag set", v & 32'h3, 2);
      chk("R12 irq from second flag", 32'(irq), 1);
      wr_done(5'h10, 32'h0);
      wr_done(5'h0C, 0);
      wr_done(5'h18, 2);
      rd(5'h14, v); chk("R11 second flag cleared", v & 32'h3, 0);

      // R10: sweep every fractional compare value while counting
      for (int a = 0; a < WRAP; a++) begin
         wr_done(5'h10, 32'h0);
         wr_done(5'h08, 32'(a));
         wr_done(5'h18, 3);
         rd(5'h14, v); chk("R10 flag clear before sweep step", v & 32'h1, 0);
         wr_done(5'h10, 32'h5);
         idle(WRAP + 1);
         rd(5'h14, v); chk("R10 compare hit in sweep", v & 32'h1, 1);
      end
      wr_done(5'h10, 32'h1);
      wr_done(5'h18, 3);
      idle(2 * WRAP);
      rd(5'h14, v); chk("R10 counting without enable sets nothing", v & 32'h3, 0);
      chk("R12 irq low without flags", 32'(irq), 0);

      // second compare sweep
      for (int a = 0; a < 4; a++) begin
         wr_done(5'h10, 32'h0);
         wr_done(5'h00, 0);
         wr_done(5'h04, 0);
         wr_done(5'h0C, 32'(a + 1));
         wr_done(5'h18, 3);
         wr_done(5'h10, 32'hB);
         idle(WRAP * (a + 2));
         rd(5'h14, v); chk("R10 second compare hit", v & 32'h2, 2);
         chk("R12 irq follows second flag", 32'(irq), 1);
      end

      done = 1;
      summary();
      $finish;
   end

endmodule